// File: doc/BRIEF.md
# Masked Packed Leading-Zero Counter

This unit takes a 512-bit vector, treats it as packed lanes of either 32 or 64 bits, and counts the zero bits at the top of each lane. The count is stopped by the first set bit. Each count is written, zero-extended, into the matching lane of a destination vector. The active part of the vector can be 128, 256 or 512 bits wide. Every destination bit above the active width is cleared.

A per-lane write mask can be enabled. When a lane's mask bit is clear, the lane either keeps the value supplied on the old-destination input (merging) or is cleared (zeroing). A broadcast option replaces the source vector with one 32-bit or 64-bit scalar, copied into every lane. Each lane count is built from a tree of small priority encoders. A 64-bit lane joins the counts of its two 32-bit halves, so both lane widths share the same counting logic.

One operation is accepted in every cycle in which `in_valid_i` is high. The result is registered and appears one clock later with `out_valid_o`. The unit produces no status flags.

Top module: `simd_lzc_unit`

## Requirements
- R1: For every active lane that is written, the result is the number of consecutive zero bits from the lane's most significant bit down to its first set bit. The result is zero-extended to the full lane width.
- R2: A lane whose source is all zeros yields the lane width: 32 in 32-bit mode, 64 in 64-bit mode.
- R3: `esz_i`=0 selects 32-bit lanes and `esz_i`=1 selects 64-bit lanes. Lane j occupies bits [j*W +: W], with lane 0 in the least significant bits.
- R4: `vlen_i` 0 selects 128 bits, 1 selects 256 bits, and 2 or 3 select 512 bits. This gives 4/8/16 active 32-bit lanes or 2/4/8 active 64-bit lanes. All destination bits above the active width read zero, whatever the mask and mode.
- R5: With `mask_en_i`=0 every active lane is written with its count. With `mask_en_i`=1, bit j of `mask_i` enables lane j, and mask bits at or above the active lane count have no effect.
- R6: For an active lane whose mask bit is clear (with `mask_en_i`=1), `zeroing_i`=0 passes through the lane from `old_dst_i` and `zeroing_i`=1 writes zero.
- R7: With `bcast_en_i`=1, bits [W-1:0] of `bcast_val_i` are the source of every active lane, and `src_i` is ignored.
- R8: Reset clears `out_valid_o` and `dst_o`. `out_valid_o` equals `in_valid_i` from the previous cycle, and `dst_o` changes only after an accepted operation.
- R9: Operations presented on consecutive cycles each produce their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation accepted this cycle |
| src_i | input | 512 | Source vector |
| bcast_val_i | input | 64 | Broadcast scalar (low 32 bits used in 32-bit mode) |
| bcast_en_i | input | 1 | Use the broadcast scalar as source |
| old_dst_i | input | 512 | Prior destination, kept in merged lanes |
| mask_i | input | 16 | Per-lane write mask |
| mask_en_i | input | 1 | Apply the write mask |
| zeroing_i | input | 1 | 1: clear masked lanes; 0: merge |
| esz_i | input | 1 | Lane width: 0 = 32 bits, 1 = 64 bits |
| vlen_i | input | 2 | Active vector length code |
| out_valid_o | output | 1 | Result valid |
| dst_o | output | 512 | Result vector |

## Verification
Masking and vector-length clearing meet whenever a mask bit is clear for a lane above the active length. In merging mode, mask handling would keep the old value there, while the length rule requires zero. The sweep provokes this by drawing random masks and random non-zero old-destination vectors for every length code in merging mode, so clear mask bits regularly fall above the active width. Each lane is then judged separately: lanes above the width must read zero and masked lanes below it must equal the old value.

// File: rtl/lzc_pkg.sv
package lzc_pkg;
  typedef enum logic {
    ESZ_D = 1'b0,
    ESZ_Q = 1'b1
  } esz_e;

  typedef enum logic [1:0] {
    VL_128 = 2'd0,
    VL_256 = 2'd1,
    VL_512 = 2'd2,
    VL_RSV = 2'd3
  } vlen_e;
endpackage

// File: rtl/lzc_prio.sv
// Recursive leading-zero priority encoder; cnt_o == W when vec_i is zero.
module lzc_prio #(
  parameter int W  = 32,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  if (W == 1) begin : g_leaf
    assign cnt_o = CW'(~vec_i[0]);
  end else begin : g_node
    localparam int HW  = W / 2;
    localparam int HCW = $clog2(HW) + 1;
    logic [HCW-1:0] hi_cnt, lo_cnt;

    lzc_prio #(.W(HW), .CW(HCW)) i_hi (.vec_i(vec_i[W-1:HW]), .cnt_o(hi_cnt));
    lzc_prio #(.W(HW), .CW(HCW)) i_lo (.vec_i(vec_i[HW-1:0]), .cnt_o(lo_cnt));

    // upper half all zero -> continue into lower half
    assign cnt_o = hi_cnt[HCW-1] ? (CW'(HW) + CW'(lo_cnt)) : CW'(hi_cnt);
  end
endmodule

// File: rtl/lzc_vlen_dec.sv
module lzc_vlen_dec #(
  parameter int NSUB    = 16,
  parameter int MIN_SUB = 4
) (
  input  logic [1:0]      vlen_i,
  output logic [NSUB-1:0] act_o
);
  localparam int NSTEP = $clog2(NSUB / MIN_SUB);

  int lim;

  always_comb begin
    if (int'(vlen_i) >= NSTEP) lim = NSUB;
    else                       lim = MIN_SUB << vlen_i;
    for (int c = 0; c < NSUB; c++) act_o[c] = (c < lim);
  end
endmodule

// File: rtl/lzc_src_sel.sv
module lzc_src_sel #(
  parameter int NSUB = 16,
  parameter int DW   = 32
) (
  input  logic [NSUB*DW-1:0] src_i,
  input  logic [2*DW-1:0]    bval_i,
  input  logic               bcast_i,
  input  logic               esz_q_i,
  output logic [NSUB*DW-1:0] src_o
);
  for (genvar c = 0; c < NSUB; c++) begin : g_sub
    logic [DW-1:0] bsel;
    // odd 32-bit slots take the scalar's upper half in 64-bit mode
    if (c % 2 == 1) begin : g_odd
      assign bsel = esz_q_i ? bval_i[2*DW-1:DW] : bval_i[DW-1:0];
    end else begin : g_even
      assign bsel = bval_i[DW-1:0];
    end
    assign src_o[c*DW +: DW] = bcast_i ? bsel : src_i[c*DW +: DW];
  end
endmodule

// File: rtl/lzc_lane_pair.sv
// One 64-bit slice: two 32-bit lanes or one 64-bit lane.
module lzc_lane_pair #(
  parameter int DW = 32
) (
  input  logic [2*DW-1:0] src_i,
  input  logic [2*DW-1:0] old_i,
  input  logic            esz_q_i,
  input  logic            mask_en_i,
  input  logic            zeroing_i,
  input  logic            m_lo_i,
  input  logic            m_hi_i,
  input  logic            m_q_i,
  input  logic            act_lo_i,
  input  logic            act_hi_i,
  output logic [2*DW-1:0] res_o
);
  localparam int CW  = $clog2(DW) + 1;
  localparam int QCW = CW + 1;

  logic [CW-1:0]  c_lo, c_hi;
  logic [QCW-1:0] c_q;
  logic [DW-1:0]  cnt_lo, cnt_hi;
  logic           we_lo, we_hi;

  lzc_prio #(.W(DW), .CW(CW)) i_lo (.vec_i(src_i[DW-1:0]),    .cnt_o(c_lo));
  lzc_prio #(.W(DW), .CW(CW)) i_hi (.vec_i(src_i[2*DW-1:DW]), .cnt_o(c_hi));

  assign c_q = c_hi[CW-1] ? (QCW'(c_hi) + QCW'(c_lo)) : QCW'(c_hi);

  always_comb begin
    if (esz_q_i) begin
      cnt_lo = DW'(c_q);
      cnt_hi = '0;
      we_lo  = !mask_en_i || m_q_i;
      we_hi  = we_lo;
    end else begin
      cnt_lo = DW'(c_lo);
      cnt_hi = DW'(c_hi);
      we_lo  = !mask_en_i || m_lo_i;
      we_hi  = !mask_en_i || m_hi_i;
    end

    if (!act_lo_i)     res_o[DW-1:0] = '0;
    else if (we_lo)    res_o[DW-1:0] = cnt_lo;
    else if (zeroing_i) res_o[DW-1:0] = '0;
    else               res_o[DW-1:0] = old_i[DW-1:0];

    if (!act_hi_i)     res_o[2*DW-1:DW] = '0;
    else if (we_hi)    res_o[2*DW-1:DW] = cnt_hi;
    else if (zeroing_i) res_o[2*DW-1:DW] = '0;
    else               res_o[2*DW-1:DW] = old_i[2*DW-1:DW];
  end
endmodule

// File: rtl/simd_lzc_unit.sv
module simd_lzc_unit
  import lzc_pkg::*;
#(
  parameter int VEC_W  = 512,
  parameter int DW     = 32,
  parameter int MIN_VL = 128
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic [VEC_W-1:0]    src_i,
  input  logic [2*DW-1:0]     bcast_val_i,
  input  logic                bcast_en_i,
  input  logic [VEC_W-1:0]    old_dst_i,
  input  logic [VEC_W/DW-1:0] mask_i,
  input  logic                mask_en_i,
  input  logic                zeroing_i,
  input  logic                esz_i,
  input  logic [1:0]          vlen_i,
  output logic                out_valid_o,
  output logic [VEC_W-1:0]    dst_o
);
  localparam int NSUB    = VEC_W / DW;
  localparam int NPAIR   = NSUB / 2;
  localparam int MIN_SUB = MIN_VL / DW;

  esz_e             esz;
  logic [NSUB-1:0]  act;
  logic [VEC_W-1:0] src_eff;
  logic [VEC_W-1:0] dst_d;

  assign esz = esz_e'(esz_i);

  lzc_vlen_dec #(.NSUB(NSUB), .MIN_SUB(MIN_SUB)) i_vdec (
    .vlen_i (vlen_i),
    .act_o  (act)
  );

  lzc_src_sel #(.NSUB(NSUB), .DW(DW)) i_ssel (
    .src_i   (src_i),
    .bval_i  (bcast_val_i),
    .bcast_i (bcast_en_i),
    .esz_q_i (esz == ESZ_Q),
    .src_o   (src_eff)
  );

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    lzc_lane_pair #(.DW(DW)) i_pair (
      .src_i     (src_eff[k*2*DW +: 2*DW]),
      .old_i     (old_dst_i[k*2*DW +: 2*DW]),
      .esz_q_i   (esz == ESZ_Q),
      .mask_en_i (mask_en_i),
      .zeroing_i (zeroing_i),
      .m_lo_i    (mask_i[2*k]),
      .m_hi_i    (mask_i[2*k+1]),
      .m_q_i     (mask_i[k]),
      .act_lo_i  (act[2*k]),
      .act_hi_i  (act[2*k+1]),
      .res_o     (dst_d[k*2*DW +: 2*DW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      dst_o       <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) dst_o <= dst_d;
    end
  end
endmodule

// File: rtl/lzc_unit_chk.sv
module lzc_unit_chk #(
  parameter int VEC_W  = 512,
  parameter int DW     = 32,
  parameter int MIN_VL = 128
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                in_valid_i,
  input logic [VEC_W-1:0]    src_i,
  input logic [2*DW-1:0]     bcast_val_i,
  input logic                bcast_en_i,
  input logic [VEC_W-1:0]    old_dst_i,
  input logic [VEC_W/DW-1:0] mask_i,
  input logic                mask_en_i,
  input logic                zeroing_i,
  input logic                esz_i,
  input logic [1:0]          vlen_i,
  input logic                out_valid_o,
  input logic [VEC_W-1:0]    dst_o
);
  assert_valid_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  assert_valid_drops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(dst_o));

  assert_upper_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && vlen_i == 2'd0) |=> (dst_o[VEC_W-1:MIN_VL] == '0));

  assert_merge_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mask_en_i && !zeroing_i && !mask_i[0])
      |=> (dst_o[DW-1:0] == $past(old_dst_i[DW-1:0])));

  assert_zero_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mask_en_i && zeroing_i && !mask_i[0]) |=> (dst_o[DW-1:0] == '0));

  assert_dword_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !esz_i && !mask_en_i) |=> (dst_o[DW-1:0] <= DW));

  assert_bcast_uniform_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && bcast_en_i && !esz_i && !mask_en_i)
      |=> (dst_o[DW-1:0] == dst_o[2*DW-1:DW]));
endmodule

bind simd_lzc_unit lzc_unit_chk #(.VEC_W(VEC_W), .DW(DW), .MIN_VL(MIN_VL)) i_chk (.*);

// File: tb/test_simd_lzc_unit.sv
`timescale 1ns/1ps
module test_simd_lzc_unit;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid = 1'b0;
  logic [511:0] src = '0;
  logic [63:0]  bval = '0;
  logic         bc = 1'b0;
  logic [511:0] old = '0;
  logic [15:0]  mask = '0;
  logic         men = 1'b0;
  logic         zr = 1'b0;
  logic         esz = 1'b0;
  logic [1:0]   vl = '0;
  logic         out_valid;
  logic [511:0] dst;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  simd_lzc_unit i_simd_lzc_unit (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .src_i(src),
    .bcast_val_i(bval), .bcast_en_i(bc), .old_dst_i(old), .mask_i(mask),
    .mask_en_i(men), .zeroing_i(zr), .esz_i(esz), .vlen_i(vl),
    .out_valid_o(out_valid), .dst_o(dst)
  );

  function automatic int clz(input logic [63:0] v, input int w);
    int n = 0;
    for (int b = w - 1; b >= 0; b--) begin
      if (v[b]) break;
      n++;
    end
    return n;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // value of width w with exactly n leading zeros
  function automatic logic [63:0] with_clz(input int n, input int w);
    logic [63:0] r;
    if (n >= w) return 64'd0;
    r = rnd64() >> (64 - w);
    r = r >> n;
    r[w-1-n] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive one op; inputs set just after a negedge, result sampled next negedge.
  task automatic op();
    int w, n, nl, cnt;
    logic [63:0] sv, ev, av;
    string tag;
    in_valid = 1'b1;
    w  = esz ? 64 : 32;
    nl = 512 / w;
    n  = ((vl == 2'd0) ? 128 : (vl == 2'd1) ? 256 : 512) / w;
    @(negedge clk);
    chk("R9", 64'(out_valid), 64'd1, "out_valid after accepted op");
    for (int j = 0; j < nl; j++) begin
      if (esz) begin
        sv = bc ? bval : src[j*64 +: 64];
        av = dst[j*64 +: 64];
      end else begin
        sv = bc ? {32'd0, bval[31:0]} : {32'd0, src[j*32 +: 32]};
        av = {32'd0, dst[j*32 +: 32]};
      end
      cnt = clz(sv, w);
      if (j >= n) begin
        ev = 64'd0; tag = "R4";
      end else if (men && !mask[j]) begin
        tag = "R6";
        if (zr) ev = 64'd0;
        else ev = esz ? old[j*64 +: 64] : {32'd0, old[j*32 +: 32]};
      end else begin
        ev = 64'(cnt);
        if (bc) tag = "R7";
        else if (men) tag = "R5";
        else if (cnt == w) tag = "R2";
        else if (esz) tag = "R3";
        else tag = "R1";
      end
      chk(tag, av, ev, $sformatf("lane %0d esz=%0d vl=%0d men=%0d zr=%0d bc=%0d",
                                 j, esz, vl, men, zr, bc));
    end
  endtask

  task automatic fill_random();
    for (int k = 0; k < 8; k++) begin
      if ($urandom() % 2 == 0) begin
        src[k*64 +: 64] = with_clz($urandom() % 65, 64);
      end else begin
        src[k*64 +: 32]      = 32'(with_clz($urandom() % 33, 32));
        src[k*64 + 32 +: 32] = 32'(with_clz($urandom() % 33, 32));
      end
      old[k*64 +: 64] = rnd64() | 64'h1;
    end
    mask = 16'($urandom());
    if ($urandom() % 2 == 0) bval = with_clz($urandom() % 65, 64);
    else bval = {$urandom(), with_clz($urandom() % 33, 32)};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8: reset state
    @(negedge clk);
    chk("R8", 64'(out_valid), 64'd0, "out_valid in reset");
    chk("R8", dst[63:0], 64'd0, "dst in reset");
    chk("R8", 64'(|dst), 64'd0, "dst any bit in reset");
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 R2 R3: every count value for both widths, full length, no mask
    for (int e = 0; e < 2; e++) begin
      esz = e[0]; vl = 2'd2; men = 1'b0; bc = 1'b0; zr = 1'b0;
      for (int base = 0; base <= (e ? 64 : 32); base++) begin
        for (int j = 0; j < (e ? 8 : 16); j++) begin
          if (e) src[j*64 +: 64] = with_clz((base + j) % 65, 64);
          else   src[j*32 +: 32] = 32'(with_clz((base + j) % 33, 32));
        end
        op();
      end
    end

    // R4 R5 R6 R7: sweep all control combinations, back to back
    for (int e = 0; e < 2; e++)
      for (int v = 0; v < 4; v++)
        for (int b = 0; b < 2; b++)
          for (int m = 0; m < 2; m++)
            for (int z = 0; z < 2; z++)
              for (int rep = 0; rep < 12; rep++) begin
                esz = e[0]; vl = v[1:0]; bc = b[0]; men = m[0]; zr = z[0];
                fill_random();
                op();
              end

    // R8: idle cycles hold result and drop valid
    begin
      logic [511:0] held;
      held = dst;
      in_valid = 1'b0;
      src = ~src; old = ~old; mask = ~mask;
      @(negedge clk);
      chk("R8", 64'(out_valid), 64'd0, "out_valid after idle");
      @(negedge clk);
      chk("R8", 64'(dst == held), 64'd1, "dst held while idle");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule